// File: doc/BRIEF.md
# Serial EEPROM Sequential Word Reader

This block is a bus master for a three-wire serial EEPROM with an active-high select line. It reads a run of consecutive 16-bit words. A single start pulse supplies the first address and the number of words. For each word the block then runs a complete, separate transaction. It raises select, waits one idle serial clock period, and sends a start bit, the read opcode and the address. It then clocks in seventeen bits, drops the leading dummy zero and keeps the sixteen data bits.

Each received word appears on a parallel output together with a single-cycle valid strobe and its position in the run. When the last word is finished, a done flag rises and stays high until the next accepted start. The address width (6 or 8 bits) is a parameter. The serial clock high and low times are set per run, as counts of system clock cycles. At 100 MHz the device minimums of 750 ns high and 250 ns low correspond to counts of 75 and 25.

Top module: `eeprom_word_reader`

## Requirements
- R1: Out of reset, and whenever the block is idle, `mem_sel`, `mem_clk` and `mem_out` are low, `busy`, `done` and `word_valid` are low, and `busy` stays low until a start is accepted.
- R2: A start pulse while idle with a nonzero count sets `busy` in the next cycle and clears `done`. Select rises, and exactly one full serial clock period passes with `mem_out` low before the start bit.
- R3: After that idle period, each transaction shifts out a 1 (start), then the opcode bits 1 and 0, then the address with its most significant bit first. The address has `ADDR_W` bits and each bit is valid at a rising `mem_clk` edge.
- R4: `mem_out` and `mem_sel` change only while `mem_clk` is low.
- R5: Each serial clock high phase lasts `hi_cycles` system clocks and each low phase lasts `lo_cycles` system clocks. A value of 0 counts as 1. The values are captured when a start is accepted.
- R6: After the address, seventeen bits are sampled on `mem_in`, each at the last system cycle of a high phase. The first bit is dropped. The other sixteen form the word, most significant bit first.
- R7: Each word is presented on `word_data` with a one-cycle `word_valid` pulse. `word_index` gives the word's position in the run, counting from 0. `word_valid` is only ever high while `busy` is high.
- R8: Words are read from addresses start through start+count-1, in increasing order and wrapping modulo 2^`ADDR_W`. Each word is a full transaction of its own.
- R9: After each word, select drops and exactly one serial clock pulse is given with select low before the next transaction or the end of the run.
- R10: After the final trailing pulse, `busy` falls and `done` rises in the same cycle. `done` stays high while idle until the next accepted start, and it is never high together with `busy`.
- R11: A start pulse while `busy` is high is ignored. The run in progress keeps its addresses, count and clock timing.
- R12: A start with a count of 0 raises `done` in the next cycle, leaves `busy` low and causes no select or clock activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start request pulse |
| start_addr | input | ADDR_W | First word address |
| word_count | input | ADDR_W+1 | Number of words to read |
| hi_cycles | input | DIV_W | Serial clock high time in system clocks |
| lo_cycles | input | DIV_W | Serial clock low time in system clocks |
| mem_sel | output | 1 | EEPROM select, active high |
| mem_clk | output | 1 | Serial clock to the EEPROM |
| mem_out | output | 1 | Serial data from master to EEPROM |
| mem_in | input | 1 | Serial data from EEPROM to master |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, held until the next start |
| word_data | output | DATA_W | Last received word |
| word_valid | output | 1 | One-cycle strobe for `word_data` |
| word_index | output | ADDR_W+1 | Position of the word in the run |

## Verification
Several properties are checked on every cycle:
- `mem_out` is steady during every high phase.
- The bus is quiet while idle.
- Each high phase lasts exactly the captured count.
- `word_valid` is a single-cycle pulse that occurs only during a run.
- `done` and `busy` are never high together.

Other behaviour can only be shown by the bench scenarios. A device model checks the frame contents: the opcode, the address order and wrap, the one idle lead period, the single trailing pulse, and the alignment of the sixteen data bits after the dummy zero. The bench also checks low-phase lengths, that a start is ignored during a run, and the zero-count case.

// File: rtl/mwr_pkg.sv
// Package: shared constants and types for the serial EEPROM word reader.
// Assumes the device uses a start bit of 1 and a 2-bit read opcode.
package mwr_pkg;

    typedef enum logic {
        RD_IDLE = 1'b0,
        RD_RUN  = 1'b1
    } rd_state_t;

    localparam logic       START_BIT = 1'b1;
    localparam logic [1:0] READ_OP   = 2'b10;
    // Lead slot, start bit and two opcode bits come before the address.
    localparam int         HDR_SLOTS = 4;

endpackage

// File: rtl/mwr_phase_timer.sv
// Module: serial clock phase timer.
// Runs a low phase of lo_len cycles, then a high phase of hi_len cycles,
// and repeats while run is high. slot_end marks the last high cycle.
// Assumes hi_len and lo_len are at least 1 and stay steady during a run.
module mwr_phase_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] hi_len,
    input  logic [DIV_W-1:0] lo_len,
    output logic             phase_hi,
    output logic             slot_end
);

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] cur_len;
    logic             last;

    // Pick the length of the phase in progress and flag its last cycle.
    always_comb begin
        cur_len  = phase_hi ? hi_len : lo_len;
        last     = (cnt == cur_len - DIV_W'(1));
        slot_end = run && phase_hi && last;
    end

    // Count cycles within a phase and flip the phase at its end.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt      <= '0;
            phase_hi <= 1'b0;
        end else if (last) begin
            cnt      <= '0;
            phase_hi <= ~phase_hi;
        end else begin
            cnt      <= cnt + DIV_W'(1);
        end
    end

endmodule

// File: rtl/mwr_cmd_bits.sv
// Module: outgoing command bit selector.
// Maps a slot number to the bit sent in that slot: lead 0, start 1,
// read opcode, then the address MSB first. Later slots send 0.
// Assumes slot counts from 0 at the lead slot of a transaction.
module mwr_cmd_bits #(
    parameter int ADDR_W = 6,
    parameter int SLOT_W = 5
) (
    input  logic [SLOT_W-1:0] slot,
    input  logic [ADDR_W-1:0] addr,
    output logic              bit_out
);

    localparam int CMD_W = mwr_pkg::HDR_SLOTS + ADDR_W;
    localparam int TAB_W = 1 << SLOT_W;

    logic [CMD_W-1:0] cmd;
    logic [TAB_W-1:0] by_slot;

    // Assemble the frame, first bit in the top position.
    always_comb cmd = {1'b0, mwr_pkg::START_BIT, mwr_pkg::READ_OP, addr};

    // Reverse the frame into slot order and pad the unused slots with 0.
    for (genvar i = 0; i < TAB_W; i++) begin : g_slot
        if (i < CMD_W) begin : g_used
            assign by_slot[i] = cmd[CMD_W-1-i];
        end else begin : g_pad
            assign by_slot[i] = 1'b0;
        end
    end

    // Select the bit for the current slot.
    always_comb bit_out = by_slot[slot];

endmodule

// File: rtl/mwr_rx_shift.sv
// Module: receive shift register.
// Shifts mem_in in on each sample strobe. After seventeen samples the
// leading dummy bit has left the register. next_word shows the word
// that the current sample completes.
module mwr_rx_shift #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              din,
    output logic [DATA_W-1:0] next_word
);

    logic [DATA_W-1:0] sh;

    // Word as it stands once the present sample is included.
    always_comb next_word = {sh[DATA_W-2:0], din};

    // Shift one received bit in, MSB first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh <= '0;
        end else if (shift_en) begin
            sh <= next_word;
        end
    end

endmodule

// File: rtl/eeprom_word_reader.sv
// Module: serial EEPROM sequential word reader (top).
// Reads word_count words starting at start_addr. Each word is a full
// transaction: a lead period with select high, start bit, read opcode,
// address, seventeen sampled bits (the first dropped), then one clock
// pulse with select low. Assumes the device drives its data on the
// rising serial clock edge.
module eeprom_word_reader #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [ADDR_W:0]   word_count,
    input  logic [DIV_W-1:0]  hi_cycles,
    input  logic [DIV_W-1:0]  lo_cycles,
    output logic              mem_sel,
    output logic              mem_clk,
    output logic              mem_out,
    input  logic              mem_in,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] word_data,
    output logic              word_valid,
    output logic [ADDR_W:0]   word_index
);

    import mwr_pkg::*;

    localparam int CNT_W      = ADDR_W + 1;
    localparam int READ_FIRST = HDR_SLOTS + ADDR_W;
    localparam int READ_LAST  = READ_FIRST + DATA_W;
    localparam int TAIL       = READ_LAST + 1;
    localparam int SLOT_W     = $clog2(TAIL + 1);

    localparam logic [SLOT_W-1:0] S_RFIRST = SLOT_W'(READ_FIRST);
    localparam logic [SLOT_W-1:0] S_RLAST  = SLOT_W'(READ_LAST);
    localparam logic [SLOT_W-1:0] S_TAIL   = SLOT_W'(TAIL);

    rd_state_t         state;
    logic [SLOT_W-1:0] slot;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  left_q;
    logic [CNT_W-1:0]  idx_q;
    logic [DIV_W-1:0]  hi_len;
    logic [DIV_W-1:0]  lo_len;
    logic              done_q;
    logic              run;
    logic              phase_hi;
    logic              slot_end;
    logic              shift_en;
    logic              cmd_bit;
    logic [DATA_W-1:0] rx_word;

    // Run flag and the strobe that samples mem_in in the read window.
    always_comb begin
        run      = (state == RD_RUN);
        shift_en = slot_end && (slot >= S_RFIRST) && (slot <= S_RLAST);
    end

    mwr_phase_timer #(.DIV_W(DIV_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .hi_len   (hi_len),
        .lo_len   (lo_len),
        .phase_hi (phase_hi),
        .slot_end (slot_end)
    );

    mwr_cmd_bits #(.ADDR_W(ADDR_W), .SLOT_W(SLOT_W)) u_cmd (
        .slot    (slot),
        .addr    (addr_q),
        .bit_out (cmd_bit)
    );

    mwr_rx_shift #(.DATA_W(DATA_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (shift_en),
        .din       (mem_in),
        .next_word (rx_word)
    );

    // Run control: accept a start, step the slots, advance words, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= RD_IDLE;
            slot       <= '0;
            addr_q     <= '0;
            left_q     <= '0;
            idx_q      <= '0;
            hi_len     <= DIV_W'(1);
            lo_len     <= DIV_W'(1);
            done_q     <= 1'b0;
            word_data  <= '0;
            word_valid <= 1'b0;
            word_index <= '0;
        end else begin
            word_valid <= 1'b0;
            case (state)
                RD_IDLE: begin
                    if (start) begin
                        if (word_count == '0) begin
                            done_q <= 1'b1;
                        end else begin
                            state  <= RD_RUN;
                            done_q <= 1'b0;
                            slot   <= '0;
                            addr_q <= start_addr;
                            left_q <= word_count;
                            idx_q  <= '0;
                            hi_len <= (hi_cycles == '0) ? DIV_W'(1) : hi_cycles;
                            lo_len <= (lo_cycles == '0) ? DIV_W'(1) : lo_cycles;
                        end
                    end
                end
                RD_RUN: begin
                    if (slot_end) begin
                        if (slot == S_RLAST) begin
                            word_data  <= rx_word;
                            word_valid <= 1'b1;
                            word_index <= idx_q;
                        end
                        if (slot == S_TAIL) begin
                            if (left_q == CNT_W'(1)) begin
                                state  <= RD_IDLE;
                                done_q <= 1'b1;
                            end else begin
                                slot   <= '0;
                                addr_q <= addr_q + ADDR_W'(1);
                                left_q <= left_q - CNT_W'(1);
                                idx_q  <= idx_q + CNT_W'(1);
                            end
                        end else begin
                            slot <= slot + SLOT_W'(1);
                        end
                    end
                end
                default: state <= RD_IDLE;
            endcase
        end
    end

    // Bus and status outputs, all gated by the run flag.
    always_comb begin
        mem_sel = run && (slot != S_TAIL);
        mem_clk = run && phase_hi;
        mem_out = mem_sel && cmd_bit;
        busy    = run;
        done    = done_q;
    end

endmodule

// File: rtl/mwr_checker.sv
// Module: protocol checker for eeprom_word_reader, attached with bind.
// Checks bus quietness, data stability while the clock is high, high
// phase length, the shape of the valid strobe, and the done/busy relation.
module mwr_checker #(
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mem_sel,
    input logic             mem_clk,
    input logic             mem_out,
    input logic             busy,
    input logic             done,
    input logic             word_valid,
    input logic [DIV_W-1:0] hi_len
);

    logic [DIV_W:0] hi_run;

    // Count consecutive cycles with the serial clock high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_run <= '0;
        end else if (mem_clk) begin
            hi_run <= hi_run + (DIV_W+1)'(1);
        end else begin
            hi_run <= '0;
        end
    end

    // R1: bus quiet while idle.
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_sel && !mem_clk && !mem_out));

    // R4: data and select steady through a high phase.
    assert_out_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_clk && $past(mem_clk)) |-> ($stable(mem_out) && $stable(mem_sel)));

    // R5: every high phase lasts the captured count.
    assert_high_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_clk) |-> (hi_run == {1'b0, hi_len}));

    // R7: valid is a single-cycle pulse.
    assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);

    // R7: valid only during a run.
    assert_valid_in_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> busy);

    // R10: done never together with busy.
    assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

endmodule

bind eeprom_word_reader mwr_checker #(.DIV_W(DIV_W)) u_mwr_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_sel    (mem_sel),
    .mem_clk    (mem_clk),
    .mem_out    (mem_out),
    .busy       (busy),
    .done       (done),
    .word_valid (word_valid),
    .hi_len     (hi_len)
);

// File: tb/test_eeprom_word_reader.sv
// Directed bench for eeprom_word_reader with a behavioural EEPROM model.
module test_eeprom_word_reader;

    localparam int ADDR_W = 6;
    localparam int DATA_W = 16;
    localparam int DIV_W  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [ADDR_W-1:0] start_addr = '0;
    logic [ADDR_W:0]   word_count = '0;
    logic [DIV_W-1:0]  hi_cycles = 8'd1;
    logic [DIV_W-1:0]  lo_cycles = 8'd1;
    logic              mem_sel, mem_clk, mem_out;
    logic              mem_in = 1'b0;
    logic              busy, done, word_valid;
    logic [DATA_W-1:0] word_data;
    logic [ADDR_W:0]   word_index;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always #5 clk = ~clk;

    eeprom_word_reader #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_W(DIV_W)) i_eeprom_word_reader (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .word_count(word_count), .hi_cycles(hi_cycles), .lo_cycles(lo_cycles),
        .mem_sel(mem_sel), .mem_clk(mem_clk), .mem_out(mem_out), .mem_in(mem_in),
        .busy(busy), .done(done), .word_data(word_data), .word_valid(word_valid),
        .word_index(word_index)
    );

    function automatic logic [15:0] mem_word(input logic [7:0] a);
        return 16'(({8'h00, a} * 16'h3B1D) ^ 16'hA5C3);
    endfunction

    // Behavioural EEPROM: decodes frames on rising serial clock edges.
    logic              dev_started = 1'b0;
    int                dev_rc = 0;
    logic [ADDR_W+1:0] dev_cmd = '0;
    logic [15:0]       dev_shift = '0;
    int                lead_rises = 0;
    int                trail_rises = 0;
    int                dev_n = 0;
    logic [1:0]        dev_op [0:63];
    logic [ADDR_W-1:0] dev_addr [0:63];

    always @(posedge mem_clk) begin
        if (!mem_sel) begin
            trail_rises++;
            dev_started <= 1'b0;
            dev_rc      <= 0;
        end else if (!dev_started) begin
            if (mem_out) dev_started <= 1'b1;
            else lead_rises++;
        end else if (dev_rc < 2 + ADDR_W) begin
            dev_cmd <= {dev_cmd[ADDR_W:0], mem_out};
            dev_rc  <= dev_rc + 1;
        end else if (dev_rc == 2 + ADDR_W) begin
            dev_op[dev_n[5:0]]   = dev_cmd[ADDR_W+1:ADDR_W];
            dev_addr[dev_n[5:0]] = dev_cmd[ADDR_W-1:0];
            dev_n++;
            dev_shift <= mem_word({2'b00, dev_cmd[ADDR_W-1:0]});
            mem_in    <= 1'b0;
            dev_rc    <= dev_rc + 1;
        end else begin
            mem_in    <= dev_shift[15];
            dev_shift <= {dev_shift[14:0], 1'b0};
            dev_rc    <= dev_rc + 1;
        end
    end

    // Output monitor sampled away from the active edge.
    int                wv_n = 0;
    logic [DATA_W-1:0] wv_data [0:63];
    logic [ADDR_W:0]   wv_idx [0:63];
    int                exp_hi = 1;
    int                exp_lo = 1;
    int                timing_bad = 0;
    int                out_bad = 0;
    int                sel_cycles = 0;
    int                hi_run = 0;
    int                lo_run = 0;
    logic              prev_clk = 1'b0;
    logic              prev_out = 1'b0;

    always @(negedge clk) begin
        if (word_valid) begin
            wv_data[wv_n[5:0]] = word_data;
            wv_idx[wv_n[5:0]]  = word_index;
            wv_n++;
        end
        if (mem_sel) sel_cycles++;
        if (mem_clk && prev_clk && mem_out != prev_out) out_bad++;
        if (mem_clk) begin
            if (!prev_clk && lo_run != exp_lo) timing_bad++;
            hi_run++;
            lo_run = 0;
        end else begin
            if (prev_clk && hi_run != exp_hi) timing_bad++;
            hi_run = 0;
            if (busy) lo_run++;
            else lo_run = 0;
        end
        prev_clk = mem_clk;
        prev_out = mem_out;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic pulse_start(input int a, input int n, input int hi, input int lo);
        @(negedge clk);
        start      = 1'b1;
        start_addr = ADDR_W'(a);
        word_count = (ADDR_W+1)'(n);
        hi_cycles  = DIV_W'(hi);
        lo_cycles  = DIV_W'(lo);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input int limit);
        for (int i = 0; i < limit && !done; i++) @(negedge clk);
    endtask

    // R1: reset state.
    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!mem_sel && !mem_clk && !mem_out, "R1", "bus idle", {mem_sel, mem_clk, mem_out}, 0);
        check(!busy && !done && !word_valid, "R1", "status idle", {busy, done, word_valid}, 0);
    endtask

    // R12: zero count finishes without bus activity.
    task automatic t_zero_count;
        int s0 = sel_cycles;
        pulse_start(9, 0, 3, 2);
        check(done == 1'b1, "R12", "done after zero count", done, 1);
        check(busy == 1'b0, "R12", "busy after zero count", busy, 0);
        repeat (20) @(negedge clk);
        check(sel_cycles == s0, "R12", "select cycles", sel_cycles - s0, 0);
        check(done == 1'b1, "R10", "done held", done, 1);
    endtask

    // R2-R10: a normal run, checked word by word.
    task automatic t_read(input int a, input int n, input int hi, input int lo, input string tag);
        int w0 = wv_n;
        int d0 = dev_n;
        int l0 = lead_rises;
        int r0 = trail_rises;
        int tb0 = timing_bad;
        int ob0 = out_bad;
        exp_hi = (hi == 0) ? 1 : hi;
        exp_lo = (lo == 0) ? 1 : lo;
        pulse_start(a, n, hi, lo);
        check(busy && !done, "R2", {tag, " busy after start"}, {busy, done}, 2);
        wait_done(n * (exp_hi + exp_lo) * 40 + 100);
        check(done && !busy, "R10", {tag, " done at end"}, {done, busy}, 2);
        check(wv_n - w0 == n, "R7", {tag, " word count"}, wv_n - w0, n);
        check(dev_n - d0 == n, "R8", {tag, " transactions"}, dev_n - d0, n);
        for (int k = 0; k < n && k < wv_n - w0 && k < dev_n - d0; k++) begin
            logic [ADDR_W-1:0] ea = ADDR_W'(a + k);
            check(dev_op[(d0+k)%64] == 2'b10, "R3", {tag, " opcode"}, dev_op[(d0+k)%64], 2);
            check(dev_addr[(d0+k)%64] == ea, "R8", {tag, " address"}, dev_addr[(d0+k)%64], ea);
            check(wv_data[(w0+k)%64] == mem_word({2'b00, ea}), "R6", {tag, " data"},
                  wv_data[(w0+k)%64], mem_word({2'b00, ea}));
            check(wv_idx[(w0+k)%64] == (ADDR_W+1)'(k), "R7", {tag, " index"}, wv_idx[(w0+k)%64], k);
        end
        check(lead_rises - l0 == n, "R2", {tag, " lead periods"}, lead_rises - l0, n);
        check(trail_rises - r0 == n, "R9", {tag, " trailing pulses"}, trail_rises - r0, n);
        check(timing_bad == tb0, "R5", {tag, " phase lengths"}, timing_bad - tb0, 0);
        check(out_bad == ob0, "R4", {tag, " data stable while high"}, out_bad - ob0, 0);
        repeat (5) @(negedge clk);
        check(done && !busy && !mem_sel, "R10", {tag, " done held"}, {done, busy, mem_sel}, 4);
    endtask

    // R11: start during a run is ignored.
    task automatic t_busy_start;
        int w0 = wv_n;
        int d0 = dev_n;
        int tb0 = timing_bad;
        exp_hi = 2;
        exp_lo = 2;
        pulse_start(10, 2, 2, 2);
        repeat (150) @(negedge clk);
        pulse_start(40, 5, 7, 7);
        wait_done(2000);
        check(wv_n - w0 == 2, "R11", "words after ignored start", wv_n - w0, 2);
        check(dev_addr[(d0+1)%64] == ADDR_W'(11), "R11", "second address", dev_addr[(d0+1)%64], 11);
        check(timing_bad == tb0, "R11", "timing unchanged", timing_bad - tb0, 0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_zero_count();
        t_read(5, 3, 3, 2, "basic");
        t_read(62, 3, 1, 1, "wrap");
        t_read(0, 1, 75, 25, "spec timing");
        t_read(33, 2, 0, 4, "zero high count");
        t_busy_start();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule